// File: doc/BRIEF.md
# Programmable Edge-Counting Down-Counter Channel

One channel of a counter/timer, built only for its counting function. A host writes a byte-wide control word into the channel and then a time constant. From then on the channel watches an external trigger line, which is asynchronous to the system clock. It resynchronises the line and counts edges of the selected polarity. Each counted edge decrements a down-counter that was loaded from the time constant.

When the counter runs down to zero, the channel pulses its zero-count output for one clock and reloads the time constant on that same clock. If interrupts are enabled and an interrupt vector has been written, it also pulses an interrupt request. The current count and the stored vector can be read on the channel's output ports. A parameter removes the zero-count output for a channel position that has no such pin.

A write on the host port is decoded from bit 0 of the byte and from whether a time constant is pending:
- A byte that follows a control word with bit 2 set is always the time constant.
- Otherwise, a byte with bit 0 set is a control word.
- Otherwise, the byte is the interrupt vector.

Top module: `edge_count_channel`

## Requirements
- R1: After reset, `count_out`, `vector_out`, `zc_out` and `irq` are all 0. Trigger edges change nothing until the channel has been programmed.
- R2: A host write with bit 0 = 0, made while no time constant is pending, stores the byte as the interrupt vector on `vector_out`. It leaves the count unchanged.
- R3: A control word with bit 2 = 1 stops counting. The next host write is taken as the time constant whatever its bit 0 is. That write loads the counter and arms the channel. Edges that arrive between the two writes are not counted.
- R4: Control bit 6 = 1 selects counter mode. With bit 6 = 0, trigger edges are not counted.
- R5: Control bit 4 selects the counted edge of `trig_in`: 1 counts rising edges, 0 counts falling edges.
- R6: A trigger level first sampled on clock edge n changes `count_out` by exactly one on clock edge n+3. This latency is made of a two-stage synchronizer, an edge register, and the decrement.
- R7: A counted edge that takes the count from 1 to 0 does three things on the same clock: it reloads the counter with the time constant, it raises `zc_out` for exactly one clock, and it leaves the count never reading 0 in between.
- R8: A time constant of 0 gives 256 counted edges between zero counts.
- R9: `irq` pulses for one clock together with each zero count only when control bit 7 = 1 and a vector has been written since reset. Otherwise it stays 0.
- R10: With `HAS_ZC` = 0, `zc_out` stays 0 while counting, reloading and `irq` behave as in R7 and R9.
- R11: A control word with bit 2 = 0, written while counting, updates polarity, mode and interrupt enable. It does not disturb the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_data | input | 8 | Host write byte (control, time constant or vector) |
| trig_in | input | 1 | External trigger, asynchronous |
| count_out | output | 8 | Current down-counter value |
| vector_out | output | 8 | Stored interrupt vector |
| zc_out | output | 1 | Zero-count pulse, one clock (tied 0 when HAS_ZC = 0) |
| irq | output | 1 | Interrupt request pulse |

## Verification
A counted edge that reaches zero and the reload of the time constant happen in the same cycle. The zero-count pulse and the interrupt pulse also coincide. The bench provokes this with time constants of 1 (every edge reaches zero) and 0 (wrap through 256). It judges the result from the count read right after the pulse, and from counters of zero-count and interrupt pulses and of pulses wider than one clock. A second instance without the zero-count pin, driven by the same inputs, must show the same interrupts and no zero-count pulse.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int BUS_W     = 8;
  localparam int B_CTRL    = 0;
  localparam int B_TCNEXT  = 2;
  localparam int B_EDGE    = 4;
  localparam int B_MODE    = 6;
  localparam int B_IE      = 7;

  typedef logic [BUS_W-1:0] byte_t;

  typedef struct packed {
    logic ie;
    logic count_mode;
    logic rise;
  } chan_cfg_t;

  function automatic logic is_ctrl(input byte_t d);
    return d[B_CTRL];
  endfunction

  function automatic logic wants_tc(input byte_t d);
    return d[B_TCNEXT];
  endfunction

  function automatic chan_cfg_t decode_cfg(input byte_t d);
    chan_cfg_t c;
    c.ie         = d[B_IE];
    c.count_mode = d[B_MODE];
    c.rise       = d[B_EDGE];
    return c;
  endfunction

  function automatic byte_t dec_one(input byte_t cnt);
    return cnt - BUS_W'(1);
  endfunction

  function automatic logic reaches_zero(input byte_t cnt);
    return cnt == BUS_W'(1);
  endfunction
endpackage

// File: rtl/ecc_trig_sync.sv
module ecc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic rise_sel,
  output logic edge_q
);
  logic [STAGES-1:0] chain;
  logic              synced;
  logic              prev;
  logic              edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], trig_in};
  end

  assign synced   = chain[STAGES-1];
  assign edge_hit = rise_sel ? (synced & ~prev) : (~synced & prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev   <= synced;
      edge_q <= edge_hit;
    end
  end
endmodule

// File: rtl/ecc_host_if.sv
module ecc_host_if
  import ecc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  byte_t     wr_data,
  output chan_cfg_t cfg,
  output logic      armed,
  output logic      tc_load,
  output byte_t     tc_val,
  output byte_t     vector,
  output logic      vec_ok
);
  logic tc_pending;
  logic ctrl_wr;
  logic vec_wr;

  assign tc_load = wr_en & tc_pending;
  assign ctrl_wr = wr_en & ~tc_pending & is_ctrl(wr_data);
  assign vec_wr  = wr_en & ~tc_pending & ~is_ctrl(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg        <= '0;
      tc_pending <= 1'b0;
      armed      <= 1'b0;
      tc_val     <= '0;
      vector     <= '0;
      vec_ok     <= 1'b0;
    end else begin
      if (tc_load) begin
        tc_val     <= wr_data;
        tc_pending <= 1'b0;
        armed      <= 1'b1;
      end
      if (ctrl_wr) begin
        cfg <= decode_cfg(wr_data);
        if (wants_tc(wr_data)) begin
          tc_pending <= 1'b1;
          armed      <= 1'b0;
        end
      end
      if (vec_wr) begin
        vector <= wr_data;
        vec_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_downcount.sv
module ecc_downcount
  import ecc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tc_load,
  input  byte_t tc_val,
  input  byte_t tc_in,
  input  logic  step,
  input  logic  irq_ok,
  output byte_t count,
  output logic  zc_evt,
  output logic  zc_q,
  output logic  irq_q
);
  assign zc_evt = step & reaches_zero(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      zc_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (tc_load)     count <= tc_in;
      else if (zc_evt) count <= tc_val;
      else if (step)   count <= dec_one(count);
      zc_q  <= zc_evt;
      irq_q <= zc_evt & irq_ok;
    end
  end
endmodule

// File: rtl/edge_count_channel.sv
module edge_count_channel
  import ecc_pkg::*;
#(
  parameter bit HAS_ZC      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             trig_in,
  output logic [BUS_W-1:0] count_out,
  output logic [BUS_W-1:0] vector_out,
  output logic             zc_out,
  output logic             irq
);
  chan_cfg_t cfg;
  logic      armed;
  logic      tc_load;
  byte_t     tc_val;
  logic      vec_ok;
  logic      edge_q;
  logic      step;
  logic      zc_evt;
  logic      zc_q;
  logic      cfg_ie;

  ecc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .rise_sel (cfg.rise),
    .edge_q   (edge_q)
  );

  ecc_host_if u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg),
    .armed   (armed),
    .tc_load (tc_load),
    .tc_val  (tc_val),
    .vector  (vector_out),
    .vec_ok  (vec_ok)
  );

  assign step   = edge_q & armed & cfg.count_mode;
  assign cfg_ie = cfg.ie;

  ecc_downcount u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tc_load (tc_load),
    .tc_val  (tc_val),
    .tc_in   (wr_data),
    .step    (step),
    .irq_ok  (cfg_ie & vec_ok),
    .count   (count_out),
    .zc_evt  (zc_evt),
    .zc_q    (zc_q),
    .irq_q   (irq)
  );

  generate
    if (HAS_ZC) begin : g_zc
      assign zc_out = zc_q;
    end else begin : g_no_zc
      assign zc_out = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] count_out,
  input logic       zc_out,
  input logic       irq,
  input logic       zc_evt,
  input logic       step,
  input logic       armed,
  input logic       tc_load,
  input logic [7:0] tc_val,
  input logic       cfg_ie,
  input logic       vec_ok
);
  AST_ZC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) zc_out |=> !zc_out); // R7
  AST_ZC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) zc_out |-> $past(zc_evt)); // R7
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) zc_evt |=> count_out == $past(tc_val)); // R7
  AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n) (step && !zc_evt) |=> count_out == $past(count_out) - 8'd1); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!armed && !tc_load) |=> $stable(count_out)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ($past(zc_evt) && $past(cfg_ie) && $past(vec_ok))); // R9
endmodule

bind edge_count_channel ecc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .count_out (count_out),
  .zc_out    (zc_out),
  .irq       (irq),
  .zc_evt    (zc_evt),
  .step      (step),
  .armed     (armed),
  .tc_load   (tc_load),
  .tc_val    (tc_val),
  .cfg_ie    (cfg_ie),
  .vec_ok    (vec_ok)
);

// File: tb/edge_count_channel_bench.sv
`timescale 1ns/1ps
module edge_count_channel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       trig_in = 1'b0;
  logic [7:0] count_out, vector_out, nz_count, nz_vector;
  logic       zc_out, irq, nz_zc, nz_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int zc_seen = 0, zc_wide = 0, irq_seen = 0, nz_zc_seen = 0, nz_irq_seen = 0;
  logic zc_last = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_count_channel u_edge_count_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .trig_in(trig_in),
    .count_out(count_out), .vector_out(vector_out), .zc_out(zc_out), .irq(irq)
  );

  edge_count_channel #(.HAS_ZC(1'b0)) u_edge_count_channel_nozc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .trig_in(trig_in),
    .count_out(nz_count), .vector_out(nz_vector), .zc_out(nz_zc), .irq(nz_irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (zc_out) zc_seen++;
      if (zc_out && zc_last) zc_wide++;
      if (irq) irq_seen++;
      if (nz_zc) nz_zc_seen++;
      if (nz_irq) nz_irq_seen++;
      zc_last = zc_out;
    end
  end

  // rows: ctrl, time constant, edge count, expected count, zero counts, irq pulses
  localparam logic [47:0] VECS [0:5] = '{
    {8'h55, 8'd5, 8'd3, 8'd2, 8'd0, 8'd0},  // R5 rising
    {8'h45, 8'd5, 8'd5, 8'd5, 8'd1, 8'd0},  // R5 falling, R7
    {8'h55, 8'd3, 8'd7, 8'd2, 8'd2, 8'd0},  // R7 repeated reload
    {8'h55, 8'd1, 8'd4, 8'd1, 8'd4, 8'd0},  // R7 every edge hits zero
    {8'h15, 8'd4, 8'd3, 8'd4, 8'd0, 8'd0},  // R4 mode bit clear
    {8'hD5, 8'd2, 8'd4, 8'd2, 8'd2, 8'd0}   // R9 no vector written
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic idle);
    trig_in = idle;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    zc_seen = 0; zc_wide = 0; irq_seen = 0; nz_zc_seen = 0; nz_irq_seen = 0; zc_last = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n, input logic active);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); trig_in = active;
      repeat (3) @(negedge clk);
      trig_in = ~active;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state and no counting before programming
    do_reset(1'b0);
    check("R1 count", count_out, 0);
    check("R1 vector", vector_out, 0);
    check("R1 zc", zc_out, 0);
    check("R1 irq", irq, 0);
    pulses(2, 1'b1);
    check("R1 unprogrammed count", count_out, 0);
    check("R1 unprogrammed zc", zc_seen, 0);

    // table of vectors
    for (int r = 0; r < 6; r++) begin
      logic [47:0] v;
      v = VECS[r];
      do_reset(~v[44]);
      host_wr(v[47:40]);
      host_wr(v[39:32]);
      pulses(int'(v[31:24]), v[44]);
      check($sformatf("R5/R7 row%0d count", r), count_out, int'(v[23:16]));
      check($sformatf("R7 row%0d zc", r), zc_seen, int'(v[15:8]));
      check($sformatf("R9 row%0d irq", r), irq_seen, int'(v[7:0]));
      check($sformatf("R10 row%0d nozc", r), nz_zc_seen, 0);
    end

    // R3 arming sequence, time constant with bit0 = 0
    do_reset(1'b0);
    host_wr(8'h55);
    pulses(2, 1'b1);
    check("R3 count before tc", count_out, 0);
    host_wr(8'h06);
    check("R3 tc load", count_out, 6);
    check("R3 tc not vector", vector_out, 0);
    pulses(1, 1'b1);
    check("R3 first edge", count_out, 5);

    // R2 vector write
    host_wr(8'hA0);
    check("R2 vector", vector_out, 8'hA0);
    check("R2 count kept", count_out, 5);

    // R11 control word without time constant
    host_wr(8'h51);
    check("R11 count kept", count_out, 5);
    pulses(1, 1'b1);
    check("R11 still counting", count_out, 4);
    host_wr(8'h41);
    pulses(1, 1'b1);
    check("R5 falling after switch", count_out, 3);

    // R6 latency
    do_reset(1'b0);
    host_wr(8'h55);
    host_wr(8'd5);
    @(negedge clk); trig_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 not yet", count_out, 5);
    @(posedge clk);
    @(negedge clk);
    check("R6 decremented", count_out, 4);
    trig_in = 1'b0;
    repeat (6) @(negedge clk);

    // R8 time constant 0 = 256
    do_reset(1'b0);
    host_wr(8'h55);
    host_wr(8'h00);
    check("R8 load", count_out, 0);
    pulses(255, 1'b1);
    check("R8 count at 255", count_out, 1);
    check("R8 no zc yet", zc_seen, 0);
    pulses(1, 1'b1);
    check("R8 zc at 256", zc_seen, 1);
    check("R8 reload", count_out, 0);
    check("R7 pulse width", zc_wide, 0);

    // R9 and R10 interrupts with vector written
    do_reset(1'b0);
    host_wr(8'h10);
    host_wr(8'hD5);
    host_wr(8'd2);
    pulses(4, 1'b1);
    check("R9 irq pulses", irq_seen, 2);
    check("R9 zc pulses", zc_seen, 2);
    check("R10 nozc irq", nz_irq_seen, 2);
    check("R10 nozc zc", nz_zc_seen, 0);
    check("R10 nozc count", nz_count, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule